// File: doc/BRIEF.md
# Iterative Leading-One Approximate Multiplier

This block multiplies two unsigned 8-bit operands without an array multiplier. Each operand is split into its highest set bit and the bits below it. The cross terms are then built from shifts and one adder. The product of the two remainders is the only part not yet covered, and it becomes the operand pair for the next step. One step completes per clock, so the caller chooses accuracy by setting how many steps may run. Stopping early gives a result at or below the exact product, never above it.

The controller has two states. `ST_IDLE` waits for `start`. From there, transition *accept* moves to `ST_RUN` when both operands are non-zero. Transition *zero_exit* stays in `ST_IDLE`, returns a zero product and pulses `done`. In `ST_RUN`, one step is taken per cycle. Transition *finish* returns to `ST_IDLE` when the leftover term is trivial or the step limit is reached. Transition *step* stays in `ST_RUN` otherwise.

Top module: `lom_mult`

## Requirements
- R1: After reset, `done` is 0, `product` is 0 and `iters_used` is 0.
- R2: If either operand is zero when `start` is accepted, `done` rises after that same clock edge. `product` is then 0 and `iters_used` is 0.
- R3: One step completes per clock. With n steps, `done` is high after the (n+1)-th rising edge, counting the edge that accepts `start` as the first.
- R4: Stepping stops early once either remainder is 0 or 1. The leftover is then added directly, so `product` is exact, and `iters_used` is the number of steps taken.
- R5: `iter_limit` is 3 bits wide. A value of 0 or 7 selects full precision. With full precision, every operand pair gives the exact product in at most 7 steps.
- R6: For `iter_limit` L in 1..6, the block stops after L steps if it has not already finished. It then outputs `op_a*op_b - ar*br`, where ar and br are the remainders left after step L. This value is never larger than the exact product.
- R7: `iters_used` never exceeds the effective limit (7 when `iter_limit` is 0).
- R8: A `start` that arrives while the block is in `ST_RUN` is ignored. The running operation's result is unchanged, and no extra `done` follows.
- R9: `done` is a one-cycle pulse. `product` and `iters_used` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (sampled in idle) |
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| iter_limit | input | 3 | Maximum step count, 0 meaning 7 |
| product | output | 16 | Exact or truncated product |
| done | output | 1 | One-cycle result-valid pulse |
| iters_used | output | 3 | Steps taken for this result |

## Verification
The hardest situation to reach is a `start` arriving mid-run. The bench gets there by launching 255 x 255, which needs the full seven steps. It then holds `start` high with different operands for three cycles while the block is still stepping. Afterwards it checks that the first result is untouched and that no second `done` follows. Truncation is covered by sweeping every limit from 1 to 6 on operands with dense remainders. Each result is compared with a leftover-subtraction model that the bench computes itself.

// File: rtl/lom_pkg.sv
package lom_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lom_state_e;
endpackage

// File: rtl/lom_lead.sv
module lom_lead #(
    parameter int W  = 8,
    parameter int JW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    output logic [JW-1:0] pos
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) pos = JW'(i);
        end
    end
endmodule

// File: rtl/lom_step.sv
module lom_step #(
    parameter int W  = 8,
    parameter int PW = 2 * W,
    parameter int JW = $clog2(W)
) (
    input  logic [W-1:0]  ra,
    input  logic [W-1:0]  rb,
    output logic [PW-1:0] term,
    output logic [W-1:0]  ar,
    output logic [W-1:0]  br,
    output logic          last
);
    logic [JW-1:0] ja, jb;
    logic [JW:0]   jsum;
    logic [PW-1:0] base, leftover;

    lom_lead #(.W(W), .JW(JW)) u_lead_a (.val(ra), .pos(ja));
    lom_lead #(.W(W), .JW(JW)) u_lead_b (.val(rb), .pos(jb));

    always_comb begin
        ar   = ra ^ (W'(1) << ja);
        br   = rb ^ (W'(1) << jb);
        jsum = {1'b0, ja} + {1'b0, jb};
        base = (PW'(1) << jsum) + (PW'(br) << ja) + (PW'(ar) << jb);
        last = (ar <= W'(1)) || (br <= W'(1));
        if (ar == '0 || br == '0)
            leftover = '0;
        else if (ar == W'(1))
            leftover = PW'(br);
        else
            leftover = PW'(ar);
        term = last ? (base + leftover) : base;
    end
endmodule

// File: rtl/lom_mult.sv
module lom_mult #(
    parameter int W  = 8,
    parameter int PW = 2 * W,
    parameter int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [CW-1:0] iter_limit,
    output logic [PW-1:0] product,
    output logic          done,
    output logic [CW-1:0] iters_used
);
    import lom_pkg::*;

    localparam int JW = $clog2(W);
    localparam logic [CW-1:0] FULL_STEPS = CW'(W - 1);

    lom_state_e    st, st_nxt;
    logic [W-1:0]  ra_q, rb_q, a_q, b_q;
    logic [PW-1:0] acc_q;
    logic [CW-1:0] cnt_q, lim_q, eff_lim, cnt_nxt;
    logic [PW-1:0] term;
    logic [W-1:0]  ar, br;
    logic          last, zero_in, stop;

    lom_step #(.W(W), .PW(PW), .JW(JW)) u_step (
        .ra(ra_q), .rb(rb_q), .term(term), .ar(ar), .br(br), .last(last)
    );

    always_comb begin
        zero_in = (op_a == '0) || (op_b == '0);
        eff_lim = (lim_q == '0) ? FULL_STEPS : lim_q;
        cnt_nxt = cnt_q + CW'(1);
        stop    = last || (cnt_nxt == eff_lim);
    end

    // next-state selection
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (start && !zero_in) st_nxt = ST_RUN;    // accept
            ST_RUN:  if (stop) st_nxt = ST_IDLE;                // finish
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra_q       <= '0;
            rb_q       <= '0;
            a_q        <= '0;
            b_q        <= '0;
            acc_q      <= '0;
            cnt_q      <= '0;
            lim_q      <= '0;
            product    <= '0;
            done       <= 1'b0;
            iters_used <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        a_q   <= op_a;
                        b_q   <= op_b;
                        ra_q  <= op_a;
                        rb_q  <= op_b;
                        lim_q <= iter_limit;
                        acc_q <= '0;
                        cnt_q <= '0;
                        if (zero_in) begin                      // zero_exit
                            product    <= '0;
                            iters_used <= '0;
                            done       <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    acc_q <= acc_q + term;
                    cnt_q <= cnt_nxt;
                    ra_q  <= ar;
                    rb_q  <= br;
                    if (stop) begin                             // finish
                        product    <= acc_q + term;
                        iters_used <= cnt_nxt;
                        done       <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lom_mult_chk.sv
module lom_mult_chk #(
    parameter int W  = 8,
    parameter int PW = 2 * W,
    parameter int CW = $clog2(W)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic [PW-1:0]       product,
    input logic [CW-1:0]       iters_used,
    input lom_pkg::lom_state_e st,
    input logic [CW-1:0]       lim_q,
    input logic [W-1:0]        a_q,
    input logic [W-1:0]        b_q
);
    import lom_pkg::*;

    logic [PW-1:0] exact;
    logic [CW-1:0] eff;
    assign exact = PW'(a_q) * PW'(b_q);
    assign eff   = (lim_q == '0) ? CW'(W - 1) : lim_q;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && iters_used == '0) |-> product == '0);

    assert_no_excess_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product <= exact);

    assert_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && iters_used < eff) |-> product == exact);

    assert_iter_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> iters_used <= eff);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |=> ($stable(a_q) && $stable(b_q) && $stable(lim_q)));

    assert_done_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(start) || $past(st == ST_RUN)));
endmodule

bind lom_mult lom_mult_chk #(.W(W), .PW(PW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .product(product), .iters_used(iters_used), .st(st),
    .lim_q(lim_q), .a_q(a_q), .b_q(b_q)
);

// File: tb/tb_lom_mult.sv
module tb_lom_mult;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_a = '0, op_b = '0;
    logic [2:0]  iter_limit = '0;
    logic [15:0] product;
    logic        done;
    logic [2:0]  iters_used;

    int n_chk = 0, n_bad = 0, cyc = 0;

    lom_mult dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .iter_limit(iter_limit), .product(product), .done(done),
        .iters_used(iters_used)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles=%0d expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int top_bit(input int x);
        int p = 1;
        while (p * 2 <= x) p = p * 2;
        return p;
    endfunction

    // leftover-subtraction model
    function automatic void model(input int a, input int b, input int lim,
                                  output int p, output int n);
        int x = a, y = b, xr, yr, lmax;
        lmax = (lim == 0) ? 7 : lim;
        p = 0; n = 0;
        if (a == 0 || b == 0) return;
        for (int it = 1; it <= 7; it++) begin
            xr = x - top_bit(x);
            yr = y - top_bit(y);
            if (xr <= 1 || yr <= 1) begin p = a * b; n = it; return; end
            if (it == lmax) begin p = a * b - xr * yr; n = it; return; end
            x = xr; y = yr;
        end
    endfunction

    task automatic run_op(input int a, input int b, input int lim, input string req);
        int k, ep, en;
        logic [15:0] held;
        model(a, b, lim, ep, en);
        @(negedge clk);
        op_a = 8'(a); op_b = 8'(b); iter_limit = 3'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 40) begin @(negedge clk); k++; end
        check({req, " R3 latency"}, k, (en == 0) ? 1 : en + 1);
        check({req, " product"}, int'(product), ep);
        check({req, " iters_used"}, int'(iters_used), en);
        if (lim != 0 && lim != 7) check({req, " R6 not above exact"}, int'(product <= 16'(a * b)), 1);
        held = product;
        @(negedge clk);
        check("R9 done one cycle", int'(done), 0);
        check("R9 product held", int'(held == product), 1);
    endtask

    task automatic t_reset();
        check("R1 done", int'(done), 0);
        check("R1 product", int'(product), 0);
        check("R1 iters_used", int'(iters_used), 0);
    endtask

    task automatic t_zero();
        run_op(0, 200, 0, "R2 a zero");
        run_op(77, 0, 3, "R2 b zero");
        run_op(0, 0, 1, "R2 both zero");
    endtask

    task automatic t_early();
        run_op(128, 77, 0, "R4 power of two");
        run_op(1, 1, 0, "R4 ones");
        run_op(130, 3, 2, "R4 small remainder");
        run_op(96, 80, 1, "R4 exit at limit step");
    endtask

    task automatic t_full();
        run_op(255, 255, 0, "R5 max lim0");
        run_op(255, 255, 7, "R5 max lim7");
        for (int a = 1; a < 256; a += 37)
            for (int b = 3; b < 256; b += 29)
                run_op(a, b, 0, "R5 sweep");
    endtask

    task automatic t_trunc();
        for (int l = 1; l <= 6; l++) begin
            run_op(255, 255, l, "R6 255x255");
            run_op(219, 187, l, "R6 219x187");
            check("R7 bound", int'(iters_used <= 3'(l)), 1);
        end
    endtask

    task automatic t_busy();
        int k;
        @(negedge clk);
        op_a = 8'd255; op_b = 8'd255; iter_limit = 3'd0; start = 1'b1;
        @(negedge clk);
        op_a = 8'd3; op_b = 8'd3; iter_limit = 3'd1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        k = 4;
        while (!done && k < 40) begin @(negedge clk); k++; end
        check("R8 busy latency", k, 8);
        check("R8 busy product", int'(product), 65025);
        check("R8 busy iters", int'(iters_used), 7);
        k = 0;
        repeat (12) begin @(negedge clk); if (done) k++; end
        check("R8 no extra done", k, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_early();
        t_full();
        t_trunc();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule